// File: doc/BRIEF.md
# Internal Operand Address Resolver

This block takes an instruction's opcode and the byte that follows it and works out where the operand lives. An operand can be a working register named in the low three opcode bits, a direct address, a pointer held in working register 0 or 1, or a literal byte. The result is a resolved 8-bit location. A flag marks locations in the special-function-register space. A second flag marks the case where the byte is a literal value and not a location at all.

Eight working registers per bank sit in a small internal RAM, which maps onto the lowest internal addresses. Two bits of the status word select which bank is in use. The RAM and the status word are loaded through a simple byte write port that uses internal addresses. Opcodes outside the supported set are flagged as illegal.

Top module: `operand_addr_resolver`

## Requirements
- R1: After reset, res_valid, res_addr, res_sfr, res_imm and res_illegal are all 0. The active bank is 0 and every working register reads 00h.
- R2: A request presented with op_valid at a rising edge gives its result with res_valid=1 for exactly the following clock cycle. res_valid is 0 in cycles that follow an edge without a request.
- R3: The register forms 11101rrr, 11111rrr and 00101rrr resolve to address {000, bank[1:0], rrr}, with res_sfr=0 and res_imm=0.
- R4: A write of value v to address D0h sets the bank to v[4:3]. Writing 00h there selects bank 0.
- R5: The direct forms E5h, F5h and 25h resolve to the operand byte. res_sfr is 1 exactly when that byte is 80h or above.
- R6: With bank 0 selected, direct address n in the range 00h to 07h resolves to the same address as register Rn.
- R7: The indirect forms 1110011i, 1111011i and 0010011i resolve to the contents of register Ri (i = 0 or 1) of the active bank. res_sfr stays 0 even when that value is 80h or above.
- R8: The immediate forms 74h and 24h give res_imm=1 and res_sfr=0, with the literal operand byte on res_addr.
- R9: Any other opcode gives res_illegal=1, with res_addr=00h, res_sfr=0 and res_imm=0.
- R10: A write to an address below 20h stores the byte in that working register. A write to any other address except D0h changes neither the registers nor the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Resolve request this cycle |
| opcode | input | 8 | Instruction opcode |
| operand | input | 8 | Byte following the opcode |
| wr_en | input | 1 | Internal byte write strobe |
| wr_addr | input | 8 | Internal write address |
| wr_data | input | 8 | Internal write data |
| res_valid | output | 1 | Result valid |
| res_addr | output | 8 | Resolved address, or the literal for immediates |
| res_sfr | output | 1 | Address lies in special-function-register space |
| res_imm | output | 1 | res_addr carries a literal value |
| res_illegal | output | 1 | Opcode not in the supported set |

## Verification
Every result is registered once, so it appears one clock edge after the edge that takes the request and stays for one cycle. A write takes effect at its own edge, so a request issued at the next edge already sees the new register or bank value. The bench changes inputs only on falling edges. It reads results on the falling edge that follows the capturing rising edge, and checks one falling edge later that res_valid has dropped.

// File: rtl/oar_pkg.sv
package oar_pkg;
  typedef enum logic [1:0] {
    MODE_REG = 2'd0,
    MODE_DIR = 2'd1,
    MODE_IND = 2'd2,
    MODE_IMM = 2'd3
  } oar_mode_e;
endpackage

// File: rtl/oar_decode.sv
module oar_decode
  import oar_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [7:0]       opcode,
  output oar_mode_e        mode,
  output logic             legal,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    mode  = MODE_REG;
    legal = 1'b1;
    sel   = '0;
    casez (opcode)
      8'b11101???, 8'b11111???, 8'b00101???: begin
        mode = MODE_REG;
        sel  = opcode[SEL_W-1:0];
      end
      8'b1110011?, 8'b1111011?, 8'b0010011?: begin
        mode = MODE_IND;
        sel  = {{(SEL_W-1){1'b0}}, opcode[0]};
      end
      8'hE5, 8'hF5, 8'h25: mode = MODE_DIR;
      8'h74, 8'h24:        mode = MODE_IMM;
      default:             legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/oar_regfile.sv
module oar_regfile #(
  parameter int          DATA_W      = 8,
  parameter int          NBANK       = 4,
  parameter int          REGS        = 8,
  parameter logic [7:0]  STATUS_ADDR = 8'hD0,
  parameter int          BANK_LSB    = 3,
  localparam int         NREG        = NBANK * REGS,
  localparam int         IDX_W       = $clog2(NREG),
  localparam int         BANK_W      = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [BANK_W-1:0] bank
);
  logic [DATA_W-1:0] mem_q [NREG];
  logic [DATA_W-1:0] mem_d [NREG];
  logic [BANK_W-1:0] bank_d;
  logic              ram_hit;

  assign ram_hit = wr_en && (wr_addr < DATA_W'(NREG));

  always_comb begin
    bank_d = bank;
    if (wr_en && wr_addr == STATUS_ADDR) bank_d = wr_data[BANK_LSB +: BANK_W];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_comb begin
      mem_d[g] = mem_q[g];
      if (ram_hit && wr_addr[IDX_W-1:0] == IDX_W'(g)) mem_d[g] = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else        mem_q[g] <= mem_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank <= '0;
    else        bank <= bank_d;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/operand_addr_resolver.sv
module operand_addr_resolver
  import oar_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          NBANK       = 4,
  parameter int          REGS        = 8,
  parameter logic [7:0]  STATUS_ADDR = 8'hD0,
  parameter int          BANK_LSB    = 3,
  parameter logic [7:0]  SFR_BASE    = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] opcode,
  input  logic [7:0] operand,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       res_valid,
  output logic [7:0] res_addr,
  output logic       res_sfr,
  output logic       res_imm,
  output logic       res_illegal
);
  localparam int NREG   = NBANK * REGS;
  localparam int IDX_W  = $clog2(NREG);
  localparam int BANK_W = $clog2(NBANK);
  localparam int SEL_W  = $clog2(REGS);

  logic [1:0]        rst_sync;
  logic              rst_q_n;
  oar_mode_e         dec_mode;
  logic              dec_legal;
  logic [SEL_W-1:0]  dec_sel;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        ptr;
  logic [BANK_W-1:0] bank;
  logic [7:0]        addr_d;
  logic              sfr_d, imm_d, ill_d;
  oar_mode_e         mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  oar_decode #(.SEL_W(SEL_W)) u_dec (
    .opcode(opcode), .mode(dec_mode), .legal(dec_legal), .sel(dec_sel)
  );

  assign idx = {bank, dec_sel};

  oar_regfile #(
    .DATA_W(DATA_W), .NBANK(NBANK), .REGS(REGS),
    .STATUS_ADDR(STATUS_ADDR), .BANK_LSB(BANK_LSB)
  ) u_rf (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_idx(idx), .rd_data(ptr), .bank(bank)
  );

  always_comb begin
    addr_d = '0;
    sfr_d  = 1'b0;
    imm_d  = 1'b0;
    ill_d  = !dec_legal;
    if (dec_legal) begin
      unique case (dec_mode)
        MODE_REG: addr_d = DATA_W'(idx);
        MODE_DIR: begin
          addr_d = operand;
          sfr_d  = (operand >= SFR_BASE);
        end
        MODE_IND: addr_d = ptr;
        MODE_IMM: begin
          addr_d = operand;
          imm_d  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_valid   <= 1'b0;
      res_addr    <= '0;
      res_sfr     <= 1'b0;
      res_imm     <= 1'b0;
      res_illegal <= 1'b0;
      mode_q      <= MODE_REG;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_addr    <= addr_d;
        res_sfr     <= sfr_d;
        res_imm     <= imm_d;
        res_illegal <= ill_d;
        mode_q      <= dec_mode;
      end
    end
  end
endmodule

// File: rtl/oar_checker.sv
module oar_checker
  import oar_pkg::*;
(
  input logic       clk,
  input logic       rst_q_n,
  input logic       op_valid,
  input logic       res_valid,
  input logic [7:0] res_addr,
  input logic       res_sfr,
  input logic       res_imm,
  input logic       res_illegal,
  input oar_mode_e  mode_q
);
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    op_valid |=> res_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_q_n)
    !op_valid |=> !res_valid);
  a_r5_sfr_only_direct: assert property (@(posedge clk) disable iff (!rst_q_n)
    (res_valid && res_sfr) |-> (mode_q == MODE_DIR && !res_illegal));
  a_r7_indirect_in_ram: assert property (@(posedge clk) disable iff (!rst_q_n)
    (res_valid && mode_q == MODE_IND) |-> !res_sfr);
  a_r8_imm_not_sfr: assert property (@(posedge clk) disable iff (!rst_q_n)
    res_imm |-> (!res_sfr && !res_illegal));
  a_r9_illegal_clean: assert property (@(posedge clk) disable iff (!rst_q_n)
    res_illegal |-> (res_addr == 8'h00 && !res_sfr && !res_imm));
  a_r3_reg_in_low_ram: assert property (@(posedge clk) disable iff (!rst_q_n)
    (res_valid && !res_illegal && mode_q == MODE_REG) |-> (res_addr < 8'h20));
endmodule

bind operand_addr_resolver oar_checker u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .op_valid(op_valid), .res_valid(res_valid),
  .res_addr(res_addr), .res_sfr(res_sfr), .res_imm(res_imm),
  .res_illegal(res_illegal), .mode_q(mode_q)
);

// File: tb/operand_addr_resolver_tb.sv
module operand_addr_resolver_tb;
  logic clk = 1'b0;
  logic rst_n, op_valid, wr_en;
  logic [7:0] opcode, operand, wr_addr, wr_data;
  logic res_valid, res_sfr, res_imm, res_illegal;
  logic [7:0] res_addr;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  operand_addr_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .operand(operand), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .res_valid(res_valid), .res_addr(res_addr), .res_sfr(res_sfr),
    .res_imm(res_imm), .res_illegal(res_illegal)
  );

  task automatic expect_out(string tag, logic v, logic [7:0] a, logic s, logic i, logic il);
    n_chk++;
    if (res_valid !== v || res_addr !== a || res_sfr !== s || res_imm !== i || res_illegal !== il) begin
      n_fail++;
      $display("FAIL %s: got v=%b a=%h s=%b i=%b il=%b, expected v=%b a=%h s=%b i=%b il=%b",
               tag, res_valid, res_addr, res_sfr, res_imm, res_illegal, v, a, s, i, il);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic req(string tag, logic [7:0] op, logic [7:0] opnd,
                     logic [7:0] a, logic s, logic i, logic il);
    @(negedge clk); op_valid = 1'b1; opcode = op; operand = opnd;
    @(negedge clk); op_valid = 1'b0;
    expect_out(tag, 1'b1, a, s, i, il);
  endtask

  task automatic t_reset();
    expect_out("R1 outputs after reset", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    req("R1 R0 clear", 8'hE6, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    req("R1 bank 0", 8'hEB, 8'h00, 8'h03, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_latency();
    req("R2 result one cycle", 8'hE9, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 valid drop: got %b expected 0", res_valid);
    end
  endtask

  task automatic t_register();
    req("R3 mov a,r0", 8'hE8, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    req("R3 mov r7,a", 8'hFF, 8'h12, 8'h07, 1'b0, 1'b0, 1'b0);
    req("R3 add r5", 8'h2D, 8'hFF, 8'h05, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bank();
    wr(8'hD0, 8'h18);
    req("R4 bank3 r2", 8'hEA, 8'h00, 8'h1A, 1'b0, 1'b0, 1'b0);
    wr(8'hD0, 8'hE7);
    req("R4 only bits4:3", 8'h2F, 8'h00, 8'h07, 1'b0, 1'b0, 1'b0);
    wr(8'hD0, 8'h08);
    req("R4 bank1 r6", 8'hFE, 8'h00, 8'h0E, 1'b0, 1'b0, 1'b0);
    wr(8'hD0, 8'h00);
    req("R4 cleared bank0", 8'hEC, 8'h00, 8'h04, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_direct();
    req("R5 ram direct", 8'hE5, 8'h30, 8'h30, 1'b0, 1'b0, 1'b0);
    req("R5 edge 7F", 8'h25, 8'h7F, 8'h7F, 1'b0, 1'b0, 1'b0);
    req("R5 edge 80", 8'hF5, 8'h80, 8'h80, 1'b1, 1'b0, 1'b0);
    req("R5 acc", 8'hE5, 8'hE0, 8'hE0, 1'b1, 1'b0, 1'b0);
    req("R6 direct 05", 8'hE5, 8'h05, 8'h05, 1'b0, 1'b0, 1'b0);
    req("R6 r5 same", 8'hED, 8'h00, 8'h05, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_indirect();
    wr(8'h00, 8'h3C);
    wr(8'h01, 8'h90);
    req("R7 @r0", 8'hE6, 8'h00, 8'h3C, 1'b0, 1'b0, 1'b0);
    req("R7 @r1 above 80", 8'hF7, 8'h00, 8'h90, 1'b0, 1'b0, 1'b0);
    wr(8'h10, 8'h44);
    wr(8'hD0, 8'h10);
    req("R7 bank2 @r0", 8'h26, 8'h00, 8'h44, 1'b0, 1'b0, 1'b0);
    wr(8'hD0, 8'h00);
  endtask

  task automatic t_immediate();
    req("R8 mov a,#", 8'h74, 8'hA5, 8'hA5, 1'b0, 1'b1, 1'b0);
    req("R8 add a,#", 8'h24, 8'hF0, 8'hF0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_illegal();
    req("R9 op 00", 8'h00, 8'h55, 8'h00, 1'b0, 1'b0, 1'b1);
    req("R9 op E4", 8'hE4, 8'h90, 8'h00, 1'b0, 1'b0, 1'b1);
    req("R9 op 88", 8'h88, 8'h90, 8'h00, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_writes();
    wr(8'h00, 8'h55);
    wr(8'h40, 8'hAA);
    wr(8'h81, 8'h18);
    wr(8'h20, 8'h77);
    req("R10 r0 kept", 8'hE6, 8'h00, 8'h55, 1'b0, 1'b0, 1'b0);
    req("R10 bank kept", 8'hEB, 8'h00, 8'h03, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; wr_en = 1'b0;
    opcode = '0; operand = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_register();
    t_bank();
    t_direct();
    t_indirect();
    t_immediate();
    t_illegal();
    t_writes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule